// File: doc/BRIEF.md
# Eager Physical Register Release Tracker

This block decides when physical registers of a renamed out-of-order core go back to the free pool. The core's results are also copied into a register value queue that feeds a trailing checker thread. Because of that copy, a register can be freed early. It is freed once its architectural name has been given a newer mapping and every renamed reader has consumed it. Older branches do not have to resolve first.

For each physical register the block tracks four things: a redefinition flag, a count of outstanding readers, the queue slot that holds a duplicate of its value, and its pool state. When a branch mispredicts, the core supplies a mask of registers that the correct path still needs. Registers in that mask that were released eagerly and are still unallocated are pulled back out of the pool. The block then issues copy-back requests one at a time, each carrying the recorded queue slot, and holds `busy` until every restored value has been acknowledged.

The rename table, the register file datapath and the queue storage are outside the block.

Top module: `erq_tracker`

## Requirements
- R1: After reset, physical registers 0 to NARCH-1 (default 32) are held and all others are in the pool. The block offers register NARCH for allocation, reports no release, and `busy` is low.
- R2: `alloc_vld` is high when the pool is non-empty and `mispredict` is low. `alloc_preg` is then the lowest-numbered pooled register. With `alloc_req` high, that register leaves the pool, and its redefinition flag, reader count and queue copy are cleared.
- R3: A held register whose redefinition flag is set, whose reader count is zero and which has a recorded queue slot is released eagerly. At most one register is released per cycle, the lowest-numbered candidate first. It is reported on `rel_vld`/`rel_preg` in that cycle and is in the pool from the next edge.
- R4: `use_inc_vld` adds one to a register's reader count and `use_dec_vld` subtracts one. A register with a non-zero count is never released eagerly.
- R5: A redefined register with no recorded queue slot is never released eagerly. It returns to the pool only through `commit_vld`.
- R6: While `slack` is 600 or more (the queue depth), no eager release takes place.
- R7: A register that is released (eagerly or by commit) in a cycle is already visible to allocation in that same cycle.
- R8: In a `mispredict` cycle there is no allocation and no release. Registers set in `restore_mask` (bit i for register i) that are in the pool because of an eager release are taken out of the pool and queued for copy-back. Other mask bits have no effect.
- R9: Copy-back requests go out in ascending register order. Each request carries the register's recorded queue slot and stays unchanged until `cb_ack`. `busy` equals `cb_req_vld` and stays high until the last restored register is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slack | input | 11 | Current lag of the checker thread, in queue entries |
| alloc_req | input | 1 | Rename takes the offered register |
| alloc_vld | output | 1 | A register is offered for allocation |
| alloc_preg | output | 7 | Offered register |
| redef_vld | input | 1 | A register's name received a newer mapping |
| redef_preg | input | 7 | Register that was superseded |
| use_inc_vld | input | 1 | A reader of a register was renamed |
| use_inc_preg | input | 7 | Register gaining a reader |
| use_dec_vld | input | 1 | A reader consumed its operand |
| use_dec_preg | input | 7 | Register losing a reader |
| rec_vld | input | 1 | Record the queue slot of a register's value |
| rec_preg | input | 7 | Register being recorded |
| rec_idx | input | 10 | Queue slot holding the duplicate |
| commit_vld | input | 1 | Conventional release at commit |
| commit_preg | input | 7 | Register released at commit |
| mispredict | input | 1 | Branch mispredict recovery cycle |
| restore_mask | input | 100 | Registers the correct path needs |
| rel_vld | output | 1 | Eager release this cycle |
| rel_preg | output | 7 | Register released eagerly |
| cb_req_vld | output | 1 | Copy-back request pending |
| cb_req_preg | output | 7 | Register to refill |
| cb_req_idx | output | 10 | Queue slot to read the value from |
| cb_ack | input | 1 | Copy-back of the current request done |
| busy | output | 1 | Copy-back still outstanding |

## Verification
The hardest situation to reach from the ports is a mispredict that finds several registers released eagerly and still unallocated. The same mask also contains registers that were never released, so the restore must pick out only the right ones. Allocation always takes the lowest pooled register, so eagerly freed registers tend to be reclaimed at once. The directed part therefore releases two registers while allocation is idle and then raises a mispredict whose mask also covers a held register. It withholds `cb_ack` for several cycles to show that the request holds steady, and then drains the copy-backs. Random traffic after that lets mispredicts land on whatever eager releases happen to survive in the pool.

// File: rtl/erq_pkg.sv
package erq_pkg;
  localparam int NPREG_D = 100;
  localparam int RVQ_D   = 600;
  localparam int NARCH_D = 32;
  localparam int CNT_W   = 4;

  typedef struct packed {
    logic             redef;
    logic [CNT_W-1:0] cnt;
    logic             qv;
    logic             pooled;
    logic             eager;
    logic             pending;
  } reg_state_t;
endpackage

// File: rtl/erq_pick.sv
module erq_pick #(
  parameter int N  = 100,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/erq_entry.sv
module erq_entry
  import erq_pkg::*;
#(
  parameter int   QW       = 10,
  parameter logic RST_POOL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_redef,
  input  logic          inc,
  input  logic          dec,
  input  logic          rec,
  input  logic [QW-1:0] rec_idx,
  input  logic          rel,
  input  logic          cfree,
  input  logic          alloc,
  input  logic          restore,
  input  logic          cb_done,
  output reg_state_t    st,
  output logic [QW-1:0] qidx
);
  reg_state_t    st_n;
  logic [QW-1:0] qidx_n;

  always_comb begin
    st_n   = st;
    qidx_n = qidx;
    if (set_redef) st_n.redef = 1'b1;
    st_n.cnt = st.cnt + CNT_W'(inc) - CNT_W'(dec);
    if (rec) begin
      st_n.qv = 1'b1;
      qidx_n  = rec_idx;
    end
    if (rel) begin
      st_n.pooled = 1'b1;
      st_n.eager  = 1'b1;
      st_n.redef  = 1'b0;
      st_n.cnt    = '0;
    end
    if (cfree) begin
      st_n.pooled = 1'b1;
      st_n.eager  = 1'b0;
      st_n.redef  = 1'b0;
    end
    if (alloc) begin
      st_n.pooled = 1'b0;
      st_n.eager  = 1'b0;
      st_n.redef  = 1'b0;
      st_n.cnt    = '0;
      st_n.qv     = 1'b0;
    end
    if (restore) begin
      st_n.pooled  = 1'b0;
      st_n.eager   = 1'b0;
      st_n.redef   = 1'b0;
      st_n.pending = 1'b1;
    end
    if (cb_done) st_n.pending = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= '0;
      st.pooled <= RST_POOL;
      qidx      <= '0;
    end else begin
      st   <= st_n;
      qidx <= qidx_n;
    end
  end
endmodule

// File: rtl/erq_tracker.sv
module erq_tracker
  import erq_pkg::*;
#(
  parameter int NPREG     = NPREG_D,
  parameter int RVQ_DEPTH = RVQ_D,
  parameter int NARCH     = NARCH_D,
  localparam int PW = $clog2(NPREG),
  localparam int QW = $clog2(RVQ_DEPTH),
  localparam int SW = QW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    slack,
  input  logic             alloc_req,
  output logic             alloc_vld,
  output logic [PW-1:0]    alloc_preg,
  input  logic             redef_vld,
  input  logic [PW-1:0]    redef_preg,
  input  logic             use_inc_vld,
  input  logic [PW-1:0]    use_inc_preg,
  input  logic             use_dec_vld,
  input  logic [PW-1:0]    use_dec_preg,
  input  logic             rec_vld,
  input  logic [PW-1:0]    rec_preg,
  input  logic [QW-1:0]    rec_idx,
  input  logic             commit_vld,
  input  logic [PW-1:0]    commit_preg,
  input  logic             mispredict,
  input  logic [NPREG-1:0] restore_mask,
  output logic             rel_vld,
  output logic [PW-1:0]    rel_preg,
  output logic             cb_req_vld,
  output logic [PW-1:0]    cb_req_preg,
  output logic [QW-1:0]    cb_req_idx,
  input  logic             cb_ack,
  output logic             busy
);
  reg_state_t    st   [NPREG];
  logic [QW-1:0] qidx [NPREG];

  logic [NPREG-1:0] rel_cand, rel_gnt, rel_oh, cfree_oh;
  logic [NPREG-1:0] pool_eff, alloc_gnt, alloc_oh;
  logic [NPREG-1:0] restore_oh, pend_vec, cb_gnt;
  logic             rel_any, alloc_any, eager_en;

  assign eager_en = (slack < SW'(RVQ_DEPTH)) && !mispredict;

  for (genvar i = 0; i < NPREG; i++) begin : g_reg
    assign rel_cand[i]   = st[i].redef && (st[i].cnt == '0) && st[i].qv && !st[i].pooled;
    assign cfree_oh[i]   = commit_vld && !mispredict && (commit_preg == PW'(i));
    assign pool_eff[i]   = st[i].pooled || rel_oh[i] || cfree_oh[i];
    assign restore_oh[i] = mispredict && restore_mask[i] && st[i].pooled && st[i].eager;
    assign pend_vec[i]   = st[i].pending;

    erq_entry #(.QW(QW), .RST_POOL(i >= NARCH)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_redef(redef_vld && (redef_preg == PW'(i))),
      .inc      (use_inc_vld && (use_inc_preg == PW'(i))),
      .dec      (use_dec_vld && (use_dec_preg == PW'(i))),
      .rec      (rec_vld && (rec_preg == PW'(i))),
      .rec_idx  (rec_idx),
      .rel      (rel_oh[i]),
      .cfree    (cfree_oh[i]),
      .alloc    (alloc_oh[i]),
      .restore  (restore_oh[i]),
      .cb_done  (cb_gnt[i] && cb_ack),
      .st       (st[i]),
      .qidx     (qidx[i])
    );
  end

  erq_pick #(.N(NPREG)) u_rel_pick (
    .req(rel_cand), .gnt(rel_gnt), .idx(rel_preg), .any(rel_any)
  );
  assign rel_vld = rel_any && eager_en;
  assign rel_oh  = eager_en ? rel_gnt : '0;

  erq_pick #(.N(NPREG)) u_alloc_pick (
    .req(pool_eff), .gnt(alloc_gnt), .idx(alloc_preg), .any(alloc_any)
  );
  assign alloc_vld = alloc_any && !mispredict;
  assign alloc_oh  = (alloc_req && alloc_vld) ? alloc_gnt : '0;

  erq_pick #(.N(NPREG)) u_cb_pick (
    .req(pend_vec), .gnt(cb_gnt), .idx(cb_req_preg), .any(cb_req_vld)
  );
  assign cb_req_idx = qidx[cb_req_preg];
  assign busy       = |pend_vec;
endmodule

// File: rtl/erq_tracker_chk.sv
module erq_tracker_chk #(
  parameter int RVQ_DEPTH = 600,
  parameter int PW = 7,
  parameter int SW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] slack,
  input logic          mispredict,
  input logic          alloc_req,
  input logic          alloc_vld,
  input logic [PW-1:0] alloc_preg,
  input logic          commit_vld,
  input logic          rel_vld,
  input logic          cb_req_vld,
  input logic [PW-1:0] cb_req_preg,
  input logic          cb_ack,
  input logic          busy
);
  a_r9_busy_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy == cb_req_vld);

  a_r8_mispredict_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> (!alloc_vld && !rel_vld));

  a_r6_lag_blocks_release: assert property (@(posedge clk) disable iff (!rst_n)
    (slack >= SW'(RVQ_DEPTH)) |-> !rel_vld);

  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_req_vld && !cb_ack && !mispredict) |=> (cb_req_vld && $stable(cb_req_preg)));

  a_r2_taken_not_reoffered: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_vld) |=> (commit_vld || !alloc_vld || alloc_preg != $past(alloc_preg)));
endmodule

bind erq_tracker erq_tracker_chk #(.RVQ_DEPTH(RVQ_DEPTH), .PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slack(slack), .mispredict(mispredict),
  .alloc_req(alloc_req), .alloc_vld(alloc_vld), .alloc_preg(alloc_preg),
  .commit_vld(commit_vld), .rel_vld(rel_vld), .cb_req_vld(cb_req_vld),
  .cb_req_preg(cb_req_preg), .cb_ack(cb_ack), .busy(busy)
);

// File: tb/tb_erq_tracker.sv
module tb_erq_tracker;
  localparam int N = 100, NA = 32, DEPTH = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [10:0] slack = '0;
  logic alloc_req = 0, redef_vld = 0, use_inc_vld = 0, use_dec_vld = 0;
  logic rec_vld = 0, commit_vld = 0, mispredict = 0, cb_ack = 0;
  logic [6:0] redef_preg = '0, use_inc_preg = '0, use_dec_preg = '0, rec_preg = '0, commit_preg = '0;
  logic [9:0] rec_idx = '0;
  logic [N-1:0] restore_mask = '0;
  logic alloc_vld, rel_vld, cb_req_vld, busy;
  logic [6:0] alloc_preg, rel_preg, cb_req_preg;
  logic [9:0] cb_req_idx;

  always #5 clk = ~clk;

  erq_tracker dut (.*);

  int m_redef[N], m_cnt[N], m_qv[N], m_qidx[N], m_pool[N], m_eager[N], m_pend[N];
  int checks = 0, fails = 0;

  function automatic int lowest_rel();
    for (int i = 0; i < N; i++)
      if (m_redef[i] != 0 && m_cnt[i] == 0 && m_qv[i] != 0 && m_pool[i] == 0) return i;
    return -1;
  endfunction

  function automatic int lowest_pend();
    for (int i = 0; i < N; i++) if (m_pend[i] != 0) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_redef[i] = 0; m_cnt[i] = 0; m_qv[i] = 0; m_qidx[i] = 0;
      m_pool[i] = (i >= NA); m_eager[i] = 0; m_pend[i] = 0;
    end
  endtask

  task automatic clear_in();
    alloc_req = 0; redef_vld = 0; use_inc_vld = 0; use_dec_vld = 0;
    rec_vld = 0; commit_vld = 0; mispredict = 0; cb_ack = 0; restore_mask = '0;
  endtask

  // Inputs are already driven (after a negedge); compare, advance model, pass the edge.
  task automatic step(input string ovr);
    int er, ea, ec;
    bit rel_en;
    #1;
    rel_en = (slack < DEPTH) && !mispredict;
    er = rel_en ? lowest_rel() : -1;
    ea = -1;
    if (!mispredict)
      for (int i = 0; i < N; i++)
        if (m_pool[i] != 0 || i == er || (commit_vld && commit_preg == i)) begin ea = i; break; end
    ec = lowest_pend();
    chk(rel_vld == (er >= 0), (ovr != "") ? ovr : (slack >= DEPTH ? "R6" : "R3"), "rel_vld", rel_vld, er >= 0);
    if (er >= 0) chk(rel_preg == er, (ovr != "") ? ovr : "R3", "rel_preg", rel_preg, er);
    chk(alloc_vld == (ea >= 0), (ovr != "") ? ovr : "R2", "alloc_vld", alloc_vld, ea >= 0);
    if (ea >= 0) chk(alloc_preg == ea, (ovr != "") ? ovr : "R2", "alloc_preg", alloc_preg, ea);
    chk(cb_req_vld == (ec >= 0), (ovr != "") ? ovr : "R9", "cb_req_vld", cb_req_vld, ec >= 0);
    chk(busy == (ec >= 0), (ovr != "") ? ovr : "R9", "busy", busy, ec >= 0);
    if (ec >= 0) begin
      chk(cb_req_preg == ec, (ovr != "") ? ovr : "R9", "cb_req_preg", cb_req_preg, ec);
      chk(cb_req_idx == m_qidx[ec], (ovr != "") ? ovr : "R9", "cb_req_idx", cb_req_idx, m_qidx[ec]);
    end
    if (redef_vld) m_redef[redef_preg] = 1;
    if (use_inc_vld) m_cnt[use_inc_preg]++;
    if (use_dec_vld) m_cnt[use_dec_preg]--;
    if (rec_vld) begin m_qv[rec_preg] = 1; m_qidx[rec_preg] = rec_idx; end
    if (er >= 0) begin m_pool[er] = 1; m_eager[er] = 1; m_redef[er] = 0; m_cnt[er] = 0; end
    if (commit_vld && !mispredict) begin m_pool[commit_preg] = 1; m_eager[commit_preg] = 0; m_redef[commit_preg] = 0; end
    if (alloc_req && ea >= 0) begin
      m_pool[ea] = 0; m_eager[ea] = 0; m_redef[ea] = 0; m_cnt[ea] = 0; m_qv[ea] = 0;
    end
    if (mispredict)
      for (int i = 0; i < N; i++)
        if (restore_mask[i] && m_pool[i] != 0 && m_eager[i] != 0) begin
          m_pool[i] = 0; m_eager[i] = 0; m_redef[i] = 0; m_pend[i] = 1;
        end
    if (cb_ack && ec >= 0) m_pend[ec] = 0;
    @(negedge clk);
    clear_in();
  endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int r, seed;
    seed = $urandom(32'h1d5e7);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1");
    // R7: register 3 released eagerly and allocated in the same cycle
    rec_vld = 1; rec_preg = 3; rec_idx = 10'd21; redef_vld = 1; redef_preg = 3; step("");
    alloc_req = 1; step("R7");
    step("");
    // R4: readers hold register 5
    rec_vld = 1; rec_preg = 5; rec_idx = 10'd77; use_inc_vld = 1; use_inc_preg = 5; step("");
    redef_vld = 1; redef_preg = 5; step("R4");
    step("R4");
    use_dec_vld = 1; use_dec_preg = 5; step("R4");
    step("R3");
    // R5: no queue copy for register 6
    redef_vld = 1; redef_preg = 6; step("R5");
    step("R5"); step("R5");
    commit_vld = 1; commit_preg = 6; step("R5");
    step("R5");
    // R6: lag at the queue depth
    slack = 11'd600; rec_vld = 1; rec_preg = 7; rec_idx = 10'd300; redef_vld = 1; redef_preg = 7; step("R6");
    step("R6"); step("R6");
    slack = 11'd599; step("R3");
    slack = 0;
    // R8/R9: two eager releases, mask also covers held register 11
    rec_vld = 1; rec_preg = 10; rec_idx = 10'd599; redef_vld = 1; redef_preg = 10; step("");
    rec_vld = 1; rec_preg = 9; rec_idx = 10'd417; redef_vld = 1; redef_preg = 9; step("");
    step("");
    mispredict = 1; restore_mask[9] = 1; restore_mask[10] = 1; restore_mask[11] = 1; step("R8");
    step("R9"); step("R9"); step("R9");
    cb_ack = 1; step("R9");
    step("R9");
    cb_ack = 1; step("R9");
    step("R8");
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      slack = ($urandom % 16 == 0) ? 11'(600 + $urandom % 60) : 11'($urandom % 600);
      if ($urandom % 48 == 0 && lowest_pend() < 0) begin
        mispredict = 1;
        for (int i = 0; i < N; i++) restore_mask[i] = $urandom % 2;
      end else begin
        alloc_req = $urandom % 2;
        cb_ack = $urandom % 2;
        r = $urandom % N;
        if (m_pool[r] == 0 && m_pend[r] == 0 && m_redef[r] == 0 && $urandom % 3 == 0) begin redef_vld = 1; redef_preg = 7'(r); end
        r = $urandom % N;
        if (m_pool[r] == 0 && m_redef[r] == 0 && m_cnt[r] < 15 && !(redef_vld && redef_preg == r)) begin use_inc_vld = 1; use_inc_preg = 7'(r); end
        r = $urandom % N;
        if (m_cnt[r] > 0 && !(use_inc_vld && use_inc_preg == r)) begin use_dec_vld = 1; use_dec_preg = 7'(r); end
        r = $urandom % N;
        if (m_pool[r] == 0 && m_redef[r] == 0 && $urandom % 2 == 0) begin rec_vld = 1; rec_preg = 7'(r); rec_idx = 10'($urandom % 600); end
        r = $urandom % N;
        if (m_pool[r] == 0 && m_redef[r] != 0 && m_qv[r] == 0) begin commit_vld = 1; commit_preg = 7'(r); end
      end
      step("");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule